// File: doc/BRIEF.md
# Retriggerable Overload Detector

This block watches a stereo pair of audio samples after the DC-removal stage. On every sample strobe it clamps both channels into a signed 18-bit range and registers them. It then compares the magnitude of each clamped value with a fixed level, 116508, which sits about 1.023 dB below digital full scale. When either channel goes past that level, an overload flag goes high. The flag is held high for a fixed number of sample periods. Every further violation restarts that hold, so the flag stays high as long as overloads keep arriving closer together than the hold time.

A standby input pulls the flag low and empties the hold timer. Because the timer is empty, the flag stays low when normal operation resumes, until a new violation arrives. The sample path keeps running during standby; only detection is suppressed. The hold is counted in sample strobes, not clock cycles. At 256 clocks per sample, the default hold of 512 strobes corresponds to 131072 clocks.

Top module: `ovld_detect`

## Requirements
- R1: On a cycle where the strobe is high, each output sample becomes, one clock later, its input clamped to the range -131072 to +131071 (input values are signed, two's complement).
- R2: In cycles without a strobe, both output samples keep their values.
- R3: On a strobe outside standby, when the clamped magnitude of the left or the right sample is greater than 116508, the flag is high from the next clock on. Either channel alone suffices, and no strobe means no rise.
- R4: A magnitude of exactly 116508 (+116508 or -116508) does not raise the flag. A magnitude of 116509 does.
- R5: The most negative clamped value, -131072, counts as magnitude 131072, and so do all inputs that clamp to it. Such a value raises the flag.
- R6: After the last violating strobe, the flag stays high through the next HOLD_SAMPLES-1 strobes that do not violate. It falls one clock after the HOLD_SAMPLES-th such strobe. Clock cycles without a strobe do not shorten the hold.
- R7: A violating strobe during the hold restarts the full hold from that strobe.
- R8: While standby is high, the flag is low from the next clock on, and violating strobes do not raise it. After standby is released, the flag stays low until a new violation.
- R9: After reset, the flag is low and both output samples are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| standby | input | 1 | Forces the flag low and clears the hold |
| left_in | input | IN_W | Left sample, signed |
| right_in | input | IN_W | Right sample, signed |
| left_out | output | OUT_W | Clamped left sample, signed |
| right_out | output | OUT_W | Clamped right sample, signed |
| ovld_flag | output | 1 | Overload flag |

## Verification
The main sweep places values on each side of the positive and negative threshold, with the other channel at zero. It tells an off-by-one or a greater-or-equal comparison apart from the correct strict comparison, and it shows that either channel triggers on its own. A second sweep steps across the full 20-bit input range, including values just past the clamp limits and the most negative code. It separates correct clamping and magnitude handling from wrap-around of negative values. Hold sequences mix clean strobes, idle cycles and renewed violations, to tell counting by strobe from counting by clock and to confirm the restart. Standby runs with violating input show that detection is suppressed and that the flag stays low after release.

// File: rtl/ovd_pkg.sv
package ovd_pkg;
    localparam int OVD_NCH       = 2;
    localparam int OVD_CH_LEFT   = 0;
    localparam int OVD_CH_RIGHT  = 1;
    localparam int OVD_DEF_LEVEL = 116508;
endpackage

// File: rtl/ovd_clamp.sv
module ovd_clamp #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 18
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [IN_W-1:0] HI = IN_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);

    always_comb begin
        if (din > HI)
            dout = HI[OUT_W-1:0];
        else if (din < LO)
            dout = LO[OUT_W-1:0];
        else
            dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/ovd_level_cmp.sv
module ovd_level_cmp #(
    parameter int W     = 18,
    parameter int LEVEL = 116508
) (
    input  logic signed [W-1:0] smp,
    output logic                over
);
    logic [W-1:0] mag;

    always_comb begin
        // unsigned view of the negated code: the most negative value maps to 2^(W-1)
        mag  = smp[W-1] ? (~smp + W'(1)) : smp;
        over = (mag > W'(LEVEL));
    end
endmodule

// File: rtl/ovld_detect.sv
module ovld_detect
    import ovd_pkg::*;
#(
    parameter int IN_W         = 20,
    parameter int OUT_W        = 18,
    parameter int LEVEL        = OVD_DEF_LEVEL,
    parameter int HOLD_SAMPLES = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic                    standby,
    input  logic signed [IN_W-1:0]  left_in,
    input  logic signed [IN_W-1:0]  right_in,
    output logic signed [OUT_W-1:0] left_out,
    output logic signed [OUT_W-1:0] right_out,
    output logic                    ovld_flag
);
    localparam int CW = $clog2(HOLD_SAMPLES + 1);

    typedef struct packed {
        logic [CW-1:0]                     cnt;
        logic                              flag;
        logic [OVD_NCH-1:0][OUT_W-1:0]     smp;
    } st_t;

    st_t st_d, st_q;

    logic [OVD_NCH-1:0][IN_W-1:0]  raw;
    logic [OVD_NCH-1:0][OUT_W-1:0] clamped;
    logic [OVD_NCH-1:0]            over;

    assign raw[OVD_CH_LEFT]  = left_in;
    assign raw[OVD_CH_RIGHT] = right_in;

    for (genvar ch = 0; ch < OVD_NCH; ch++) begin : g_ch
        logic signed [OUT_W-1:0] c_s;

        ovd_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clamp (
            .din  ($signed(raw[ch])),
            .dout (c_s)
        );

        ovd_level_cmp #(.W(OUT_W), .LEVEL(LEVEL)) u_cmp (
            .smp  (c_s),
            .over (over[ch])
        );

        assign clamped[ch] = c_s;
    end

    always_comb begin
        st_d = st_q;
        if (smp_stb)
            st_d.smp = clamped;
        if (standby)
            st_d.cnt = '0;
        else if (smp_stb) begin
            if (|over)
                st_d.cnt = CW'(HOLD_SAMPLES);
            else if (st_q.cnt != '0)
                st_d.cnt = st_q.cnt - CW'(1);
        end
        st_d.flag = !standby && (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign left_out  = st_q.smp[OVD_CH_LEFT];
    assign right_out = st_q.smp[OVD_CH_RIGHT];
    assign ovld_flag = st_q.flag;
endmodule

// File: rtl/ovd_chk.sv
module ovd_chk #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 18,
    parameter int LEVEL = 116508
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_stb,
    input logic                    standby,
    input logic signed [IN_W-1:0]  left_in,
    input logic signed [IN_W-1:0]  right_in,
    input logic signed [OUT_W-1:0] left_out,
    input logic signed [OUT_W-1:0] right_out,
    input logic                    ovld_flag
);
    localparam logic signed [IN_W-1:0] POS = IN_W'(LEVEL);
    localparam logic signed [IN_W-1:0] NEG = -POS;

    logic big_in;
    assign big_in = (left_in > POS) || (left_in < NEG) ||
                    (right_in > POS) || (right_in < NEG);

    assert_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !standby && big_in) |=> ovld_flag);

    assert_no_rise_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !$rose(ovld_flag));

    assert_hold_samples_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(left_out) && $stable(right_out)));

    assert_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovld_flag) |-> ($past(smp_stb) || $past(standby)));

    assert_standby_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !ovld_flag);
endmodule

bind ovld_detect ovd_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .LEVEL(LEVEL)) u_ovd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .standby   (standby),
    .left_in   (left_in),
    .right_in  (right_in),
    .left_out  (left_out),
    .right_out (right_out),
    .ovld_flag (ovld_flag)
);

// File: tb/ovld_detect_bench.sv
module ovld_detect_bench;
    localparam int HOLD = 8;
    localparam int LVL  = 116508;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic standby = 1'b0;
    logic signed [19:0] left_in = '0;
    logic signed [19:0] right_in = '0;
    logic signed [17:0] left_out, right_out;
    logic ovld_flag;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #10 clk = ~clk;

    ovld_detect #(.IN_W(20), .OUT_W(18), .LEVEL(LVL), .HOLD_SAMPLES(HOLD)) u_ovld_detect (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .standby(standby),
        .left_in(left_in), .right_in(right_in),
        .left_out(left_out), .right_out(right_out), .ovld_flag(ovld_flag)
    );

    function automatic int clampv(int v);
        if (v > 131071) return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    function automatic bit violates(int v);
        int c;
        c = clampv(v);
        return (c > LVL) || (-c > LVL);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one strobe; outputs checked at the following falling edge
    task automatic strobe(int l, int r, string tag);
        @(negedge clk);
        left_in  = 20'(l);
        right_in = 20'(r);
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        if (standby) exp_cnt = 0;
        else if (violates(l) || violates(r)) exp_cnt = HOLD;
        else if (exp_cnt > 0) exp_cnt--;
        chk(int'(left_out) == clampv(l), {tag, " R1 left"}, int'(left_out), clampv(l));
        chk(int'(right_out) == clampv(r), {tag, " R1 right"}, int'(right_out), clampv(r));
        chk(ovld_flag == (exp_cnt != 0), {tag, " flag"}, int'(ovld_flag), int'(exp_cnt != 0));
    endtask

    task automatic clear_flag();
        @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        exp_cnt = 0;
        chk(ovld_flag == 1'b0, "R8 standby clears", int'(ovld_flag), 0);
    endtask

    task automatic one_point(int v, string tag);
        clear_flag();
        strobe(v, 0, {tag, " left"});
        clear_flag();
        strobe(0, v, {tag, " right"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ovld_flag == 1'b0, "R9 flag", int'(ovld_flag), 0);
        chk(left_out == '0 && right_out == '0, "R9 samples", int'(left_out), 0);
        rst_n = 1'b1;

        // R4: threshold edges on both signs and both channels
        for (int off = -3; off <= 3; off++) begin
            one_point(LVL + off, "R4 pos");
            one_point(-LVL + off, "R4 neg");
        end
        // R5 and R1: clamp edges and most negative code
        one_point(131071, "R1 max");
        one_point(131072, "R1 over max");
        one_point(-131072, "R5 min");
        one_point(-131073, "R5 below min");
        one_point(524287, "R1 top");
        one_point(-524288, "R5 bottom");
        // R3: sweep across the input range
        for (int v = -524288; v < 524288; v += 2039)
            one_point(v, "R3 sweep");

        // R2: idle cycles keep the samples
        clear_flag();
        strobe(12345, -54321, "R2 load");
        repeat (5) @(negedge clk);
        chk(int'(left_out) == 12345, "R2 left held", int'(left_out), 12345);
        chk(int'(right_out) == -54321, "R2 right held", int'(right_out), -54321);
        chk(ovld_flag == 1'b0, "R3 no rise", int'(ovld_flag), 0);

        // R6: hold counted in strobes, idle cycles in between
        clear_flag();
        strobe(120000, 0, "R6 trigger");
        for (int i = 1; i <= HOLD; i++) begin
            repeat (3) @(negedge clk);
            chk(ovld_flag == 1'b1, "R6 idle keeps", int'(ovld_flag), 1);
            strobe(100, -100, "R6 hold");
        end
        chk(ovld_flag == 1'b0, "R6 falls", int'(ovld_flag), 0);

        // R7: retrigger restarts the hold
        strobe(0, -120000, "R7 first");
        for (int i = 0; i < 5; i++) strobe(1, 1, "R7 mid");
        strobe(-116509, 0, "R7 again");
        for (int i = 0; i < HOLD; i++) strobe(2, 2, "R7 hold");
        chk(ovld_flag == 1'b0, "R7 final low", int'(ovld_flag), 0);

        // R8: violations ignored in standby, low after release
        strobe(130000, 0, "R8 pre");
        @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        exp_cnt = 0;
        chk(ovld_flag == 1'b0, "R8 forced low", int'(ovld_flag), 0);
        strobe(-131072, 131071, "R8 in standby");
        strobe(200000, 0, "R8 in standby");
        @(negedge clk);
        standby = 1'b0;
        repeat (3) @(negedge clk);
        chk(ovld_flag == 1'b0, "R8 after release", int'(ovld_flag), 0);
        strobe(5, 5, "R8 clean after");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule